// File: doc/BRIEF.md
# Six-Channel Shadowed PWM Controller

This block produces six independent pulse-width-modulated outputs. All six are programmed over one word-wide register bus. Each channel counts cycles of the single input clock. A channel's period is split into a first phase and a second phase. The first phase lasts for the programmed duty count and is driven at a selectable level. The second phase fills the rest of the period at the opposite level.

New period and duty values are written into staging registers and have no effect on their own. A commit bit in the control register marks them as pending. The running channel picks up the pending values only on the clock edge that ends its current period, so a reconfiguration never cuts a period short. A separate start bit launches a stopped channel, and on launch the staged values are taken at once.

Each channel is one small state machine with two states:

- `CH_STOPPED`: the output sits at the inactive level.
- `CH_RUNNING`: the period counter advances.

The machine has two transitions:

- *launch* (`CH_STOPPED` to `CH_RUNNING`): a control write with the start bit set.
- *halt* (`CH_RUNNING` to `CH_STOPPED`): a control write with the start bit clear.

Inside `CH_RUNNING`, the *period-end reload* moves pending values into the active registers.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: After reset, every output is low and every control register reads 0x00000100 (first-phase level 1). Every period and duty register reads 0.
- R2: Channel n occupies byte addresses n×0x20 and up. Within that window, control is at +0x00, period at +0x08 and duty at +0x0C. Period and duty read back their staged values. Any other address reads 0, and writes to it change nothing.
- R3: The control register bits are: bit 0 start (reads 1 while running), bit 2 commit (reads 1 while values are pending), bit 5 continuous (stored) and bit 8 first-phase level. A write takes effect on the clock edge that samples it.
- R4: A control write with bit 0 set to a stopped channel starts it on that edge. The channel loads the staged period and duty, takes the first-phase level from that write, restarts the count at 0 and clears any pending commit. From then on the output is at the first-phase level while count < duty and at the opposite level otherwise.
- R5: A stopped channel drives the inverse of its control bit 8.
- R6: A period of 0 drives the inverse of the active first-phase level, and the period ends on every cycle. A duty of 0 gives the second-phase level for the whole period. A duty ≥ period gives the first-phase level for the whole period.
- R7: A commit while running leaves the current period unchanged. The pending period, duty and control bit 8 are loaded on the edge where the count equals period−1, and the count restarts at 0. Bit 2 reads 1 until that load and 0 after it.
- R8: Period or duty writes without a commit do not change the output.
- R9: A control write with bit 0 set to a running channel does not restart its count.
- R10: A control write with bit 0 clear to a running channel stops it on that edge.
- R11: A commit written on the period-ending edge itself is not taken by that reload. It stays pending and is applied at the end of the following period.
- R12: A write to one channel never changes another channel's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 6 | One PWM output per channel |

## Verification
A commit written on a running channel and that channel's own period-end reload can land on the same edge. The bench steps a cycle-level model alongside the design and idles until the model's count reaches period−1. It then issues the commit write on exactly that edge. The scoreboard requires the old waveform to run one more full period, a read of the control register in between must show the commit bit still set, and the new values must appear only at the following period end.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Address stride between channel register blocks (2**5 = 0x20 bytes)
    localparam int STRIDE_LOG2 = 5;

    localparam logic [STRIDE_LOG2-1:0] OFS_CTRL = 5'h00;
    localparam logic [STRIDE_LOG2-1:0] OFS_PER  = 5'h08;
    localparam logic [STRIDE_LOG2-1:0] OFS_DUTY = 5'h0C;

    // Control register bit positions
    localparam int BIT_START  = 0;
    localparam int BIT_COMMIT = 2;
    localparam int BIT_CONT   = 5;
    localparam int BIT_LEVEL  = 8;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_PER,
        SEL_DUTY
    } reg_sel_t;

endpackage

// File: rtl/pwm_bus_decode.sv
module pwm_bus_decode
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [NUM_CH-1:0] wr_ctrl,
    output logic [NUM_CH-1:0] wr_per,
    output logic [NUM_CH-1:0] wr_duty,
    output logic [NUM_CH-1:0] rd_hit,
    output reg_sel_t          rd_sel
);
    localparam int IDX_W = ADDR_W - STRIDE_LOG2;

    logic [IDX_W-1:0]       idx;
    logic [STRIDE_LOG2-1:0] ofs;
    reg_sel_t               sel;

    assign idx = bus_addr[ADDR_W-1:STRIDE_LOG2];
    assign ofs = bus_addr[STRIDE_LOG2-1:0];

    always_comb begin
        unique case (ofs)
            OFS_CTRL: sel = SEL_CTRL;
            OFS_PER:  sel = SEL_PER;
            OFS_DUTY: sel = SEL_DUTY;
            default:  sel = SEL_NONE;
        endcase
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        assign hit        = (idx == IDX_W'(i)) && (sel != SEL_NONE);
        assign rd_hit[i]  = hit;
        assign wr_ctrl[i] = bus_wr && hit && (sel == SEL_CTRL);
        assign wr_per[i]  = bus_wr && hit && (sel == SEL_PER);
        assign wr_duty[i] = bus_wr && hit && (sel == SEL_DUTY);
    end

    assign rd_sel = sel;

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_per,
    input  logic              wr_duty,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] per_rd,
    output logic [DATA_W-1:0] duty_rd,
    output logic              pwm_o,
    output logic              run_o,
    output logic              pend_o,
    output logic              lvl_o
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    ch_state_t         st_q, st_d;
    logic              launch, halt, bound;
    logic [DATA_W-1:0] stg_per_q, stg_duty_q;
    logic [DATA_W-1:0] act_per_q, act_duty_q, cnt_q;
    logic [DATA_W-1:0] act_per_d, act_duty_d, cnt_d;
    logic              act_lvl_q, act_lvl_d;
    logic              cfg_lvl_q, cfg_lvl_d;
    logic              cont_q, pend_q, pend_d;
    logic              out_q, out_d;

    // Events decoded from the current state and the bus
    assign launch = (st_q == CH_STOPPED) && wr_ctrl && wdata[BIT_START];
    assign halt   = (st_q == CH_RUNNING) && wr_ctrl && !wdata[BIT_START];
    assign bound  = (st_q == CH_RUNNING) &&
                    ((act_per_q == '0) || (cnt_q == act_per_q - ONE));

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_STOPPED: if (launch) st_d = CH_RUNNING;
            CH_RUNNING: if (halt)   st_d = CH_STOPPED;
            default:                st_d = CH_STOPPED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_STOPPED;
        else        st_q <= st_d;
    end

    // Counter, active set and pending flag
    always_comb begin
        act_per_d  = act_per_q;
        act_duty_d = act_duty_q;
        act_lvl_d  = act_lvl_q;
        cnt_d      = cnt_q;
        pend_d     = pend_q;
        if (launch) begin
            act_per_d  = stg_per_q;
            act_duty_d = stg_duty_q;
            act_lvl_d  = wdata[BIT_LEVEL];
            cnt_d      = '0;
            pend_d     = 1'b0;
        end else if (halt) begin
            cnt_d = '0;
        end else if (st_q == CH_RUNNING) begin
            if (bound) begin
                cnt_d = '0;
                if (pend_q) begin
                    act_per_d  = stg_per_q;
                    act_duty_d = stg_duty_q;
                    act_lvl_d  = cfg_lvl_q;
                    pend_d     = 1'b0;
                end
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
        // A fresh commit wins over a reload on the same edge
        if (wr_ctrl && wdata[BIT_COMMIT] && !launch) pend_d = 1'b1;
    end

    assign cfg_lvl_d = wr_ctrl ? wdata[BIT_LEVEL] : cfg_lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_per_q  <= '0;
            stg_duty_q <= '0;
            act_per_q  <= '0;
            act_duty_q <= '0;
            act_lvl_q  <= 1'b1;
            cnt_q      <= '0;
            pend_q     <= 1'b0;
            cfg_lvl_q  <= 1'b1;
            cont_q     <= 1'b0;
        end else begin
            if (wr_per)  stg_per_q  <= wdata;
            if (wr_duty) stg_duty_q <= wdata;
            if (wr_ctrl) cont_q     <= wdata[BIT_CONT];
            act_per_q  <= act_per_d;
            act_duty_q <= act_duty_d;
            act_lvl_q  <= act_lvl_d;
            cnt_q      <= cnt_d;
            pend_q     <= pend_d;
            cfg_lvl_q  <= cfg_lvl_d;
        end
    end

    // Output level, evaluated on next-cycle values and registered
    always_comb begin
        if (st_d == CH_RUNNING) begin
            if (act_per_d == '0)          out_d = !act_lvl_d;
            else if (cnt_d < act_duty_d)  out_d = act_lvl_d;
            else                          out_d = !act_lvl_d;
        end else begin
            out_d = !cfg_lvl_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    always_comb begin
        ctrl_rd            = '0;
        ctrl_rd[BIT_START] = (st_q == CH_RUNNING);
        ctrl_rd[BIT_COMMIT] = pend_q;
        ctrl_rd[BIT_CONT]  = cont_q;
        ctrl_rd[BIT_LEVEL] = cfg_lvl_q;
    end

    assign per_rd  = stg_per_q;
    assign duty_rd = stg_duty_q;
    assign pwm_o   = out_q;
    assign run_o   = (st_q == CH_RUNNING);
    assign pend_o  = pend_q;
    assign lvl_o   = cfg_lvl_q;

endmodule

// File: rtl/pwm_multi_ctrl.sv
module pwm_multi_ctrl
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    logic [NUM_CH-1:0] wr_ctrl, wr_per, wr_duty, rd_hit;
    reg_sel_t          rd_sel;
    logic [DATA_W-1:0] ctrl_rd [NUM_CH];
    logic [DATA_W-1:0] per_rd  [NUM_CH];
    logic [DATA_W-1:0] duty_rd [NUM_CH];
    logic [NUM_CH-1:0] ch_run, ch_pend, ch_lvl;

    pwm_bus_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_ctrl  (wr_ctrl),
        .wr_per   (wr_per),
        .wr_duty  (wr_duty),
        .rd_hit   (rd_hit),
        .rd_sel   (rd_sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        pwm_channel #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_ctrl (wr_ctrl[i]),
            .wr_per  (wr_per[i]),
            .wr_duty (wr_duty[i]),
            .wdata   (bus_wdata),
            .ctrl_rd (ctrl_rd[i]),
            .per_rd  (per_rd[i]),
            .duty_rd (duty_rd[i]),
            .pwm_o   (pwm_out[i]),
            .run_o   (ch_run[i]),
            .pend_o  (ch_pend[i]),
            .lvl_o   (ch_lvl[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_hit[i]) begin
                case (rd_sel)
                    SEL_CTRL: bus_rdata = ctrl_rd[i];
                    SEL_PER:  bus_rdata = per_rd[i];
                    SEL_DUTY: bus_rdata = duty_rd[i];
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_multi_ctrl_chk.sv
module pwm_multi_ctrl_chk
    import pwm_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wr_start,
    input logic [NUM_CH-1:0] pwm_out,
    input logic [NUM_CH-1:0] ch_run,
    input logic [NUM_CH-1:0] ch_pend,
    input logic [NUM_CH-1:0] ch_lvl
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(i << STRIDE_LOG2);
        logic ctrl_wr;
        assign ctrl_wr = bus_wr && (bus_addr == CTRL_A);

        assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_run[i] |-> (pwm_out[i] == !ch_lvl[i]));

        assert_launch_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_run[i]) |-> !ch_pend[i]);

        assert_launch_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_run[i] && ctrl_wr && wr_start) |=> ch_run[i]);

        assert_no_restart_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_run[i] && ctrl_wr && wr_start) |=> ch_run[i]);

        assert_halt_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_wr && !wr_start) |=> !ch_run[i]);
    end
endmodule

bind pwm_multi_ctrl pwm_multi_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wr_start (bus_wdata[pwm_pkg::BIT_START]),
    .pwm_out  (pwm_out),
    .ch_run   (ch_run),
    .ch_pend  (ch_pend),
    .ch_lvl   (ch_lvl)
);

// File: tb/pwm_multi_ctrl_bench.sv
`timescale 1ns/1ps
module pwm_multi_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  pwm_out;

    pwm_multi_ctrl u_pwm_multi_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    ch;
        logic  lvl;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    // Cycle-level reference of the channel under test, built from the requirements
    int          mch;
    logic        m_run, m_pend, m_cfg, m_cont, m_alvl;
    logic [31:0] m_sper, m_sduty, m_aper, m_aduty, m_cnt;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset(input int ch);
        mch = ch;
        m_run = 0; m_pend = 0; m_cfg = 1; m_cont = 0; m_alvl = 1;
        m_sper = 0; m_sduty = 0; m_aper = 0; m_aduty = 0; m_cnt = 0;
    endtask

    function automatic logic model_level();
        if (!m_run)                return !m_cfg;
        if (m_aper == 0)           return !m_alvl;
        if (m_cnt < m_aduty)       return m_alvl;
        return !m_alvl;
    endfunction

    function automatic logic [31:0] model_ctrl();
        return {23'd0, m_cfg, 2'b00, m_cont, 2'b00, m_pend, 1'b0, m_run};
    endfunction

    task automatic model_step(input bit w, input logic [7:0] a, input logic [31:0] d);
        bit wc, wp, wd, launch, halt, bnd, old_pend;
        wc = w && (a == 8'(mch * 32));
        wp = w && (a == 8'(mch * 32 + 8));
        wd = w && (a == 8'(mch * 32 + 12));
        launch = !m_run && wc && d[0];
        halt = m_run && wc && !d[0];
        bnd = m_run && ((m_aper == 0) || (m_cnt == m_aper - 1));
        old_pend = m_pend;
        if (launch) begin
            m_aper = m_sper; m_aduty = m_sduty; m_alvl = d[8];
            m_cnt = 0; m_run = 1; m_pend = 0;
        end else if (halt) begin
            m_run = 0; m_cnt = 0;
        end else if (m_run) begin
            if (bnd) begin
                m_cnt = 0;
                if (old_pend) begin
                    m_aper = m_sper; m_aduty = m_sduty; m_alvl = m_cfg; m_pend = 0;
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
        if (wc && d[2] && !launch) m_pend = 1;
        if (wc) begin m_cfg = d[8]; m_cont = d[5]; end
        if (wp) m_sper = d;
        if (wd) m_sduty = d;
    endtask

    // Driver: one bus cycle, with the expected post-edge output queued
    task automatic cyc(input bit w, input logic [7:0] a, input logic [31:0] d, input string req);
        exp_t e;
        @(negedge clk);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        model_step(w, a, d);
        e.ch = mch; e.lvl = model_level(); e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        cyc(1'b1, a, d, req);
    endtask

    task automatic idle(input int n, input string req);
        for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 32'h0, req);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        exp_t e;
        @(negedge clk);
        bus_wr = 0; bus_addr = a; bus_wdata = 0;
        #1;
        chk(bus_rdata == exp, req, bus_rdata, exp);
        model_step(1'b0, a, 32'h0);
        e.ch = mch; e.lvl = model_level(); e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pop one expectation per clock, sampled after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                chk(pwm_out[e.ch] == e.lvl, e.req, 32'(pwm_out[e.ch]), 32'(e.lvl));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        model_reset(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        chk(pwm_out == 6'h00, "R1", 32'(pwm_out), 32'h0);
        rd(8'h00, 32'h100, "R1");
        rd(8'h08, 32'h0, "R1");
        rd(8'h0C, 32'h0, "R1");
        rd(8'hA0, 32'h100, "R1");

        // Staged values and control bits on channel 0
        wr(8'h08, 32'd8, "R2");
        wr(8'h0C, 32'd3, "R2");
        rd(8'h08, 32'd8, "R2");
        rd(8'h0C, 32'd3, "R2");
        wr(8'h00, 32'h124, "R3");
        rd(8'h00, 32'h124, "R3");

        // Launch: period 8, duty 3, first phase high
        wr(8'h00, 32'h121, "R4");
        rd(8'h00, 32'h121, "R4");
        idle(16, "R4");

        // Staged without commit
        wr(8'h08, 32'd5, "R8");
        wr(8'h0C, 32'd2, "R8");
        idle(10, "R8");

        // Start rewritten while running
        wr(8'h00, 32'h121, "R9");
        idle(8, "R9");

        // Commit while running, applied at period end
        wr(8'h00, 32'h125, "R7");
        idle(18, "R7");
        rd(8'h00, 32'h121, "R7");

        // Commit on the period-ending edge
        wr(8'h08, 32'd6, "R11");
        wr(8'h0C, 32'd4, "R11");
        while (!(m_run && (m_cnt == m_aper - 1))) cyc(1'b0, 8'h00, 32'h0, "R11");
        wr(8'h00, 32'h125, "R11");
        rd(8'h00, 32'h125, "R11");
        idle(14, "R11");
        rd(8'h00, 32'h121, "R11");

        // Halt
        wr(8'h00, 32'h120, "R10");
        idle(3, "R10");
        rd(8'h00, 32'h120, "R10");

        // Channel 1: idle level, inverted polarity, edge cases
        model_reset(1);
        wr(8'h20, 32'h020, "R5");
        idle(2, "R5");
        wr(8'h28, 32'd6, "R4");
        wr(8'h2C, 32'd2, "R4");
        wr(8'h20, 32'h021, "R4");
        idle(14, "R4");
        wr(8'h2C, 32'd0, "R6");
        wr(8'h20, 32'h125, "R6");
        idle(14, "R6");
        wr(8'h2C, 32'd9, "R6");
        wr(8'h20, 32'h125, "R6");
        idle(14, "R6");
        wr(8'h28, 32'd0, "R6");
        wr(8'h20, 32'h125, "R6");
        idle(8, "R6");
        wr(8'h28, 32'd3, "R6");
        wr(8'h2C, 32'd1, "R6");
        wr(8'h20, 32'h125, "R6");
        idle(8, "R6");

        // Isolation and unmapped space
        wr(8'hB0, 32'hFFFF_FFFF, "R2");
        wr(8'h04, 32'hFFFF_FFFF, "R2");
        rd(8'hB0, 32'h0, "R2");
        rd(8'h04, 32'h0, "R2");
        rd(8'hA8, 32'h0, "R2");
        rd(8'h00, 32'h120, "R12");
        wait (sb_q.size() == 0);
        @(negedge clk);
        chk(pwm_out[0] == 1'b0, "R12", 32'(pwm_out[0]), 32'h0);
        chk(pwm_out[5:2] == 4'h0, "R12", 32'(pwm_out[5:2]), 32'h0);
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule